// File: doc/BRIEF.md
# Optical Transmit Modulator

This block drives a single optical (infrared) transmit pin. A two-bit source select picks what reaches the pin: the serial transmit bit of a UART, a general-purpose output bit, or one of two energy pulse outputs (real energy and reactive energy). When the UART is the source, the block can send the transmit level straight through. It can also key a roughly 38 kHz carrier with that level. In that case a space (UART low) sends carrier bursts and a mark (UART high) leaves the pin idle.

The carrier comes from a free-running divider. The divider counts `CARRIER_DIV` system clocks per carrier period. The default of 5264 clocks at 200 MHz is close to 38 kHz. The high part of each carrier period is set by a duty code and is measured in eighths of the period. A final invert control flips the pin polarity for every source. The output is registered, so the pin follows its inputs one clock later.

Top module: `optx_modulator`

## Requirements
- R1: The carrier phase counter starts at 0 on the first clock edge after reset. It then advances by one each clock and returns to 0 after `CARRIER_DIV`-1, so the carrier period is exactly `CARRIER_DIV` clocks.
- R2: With source select 0 (UART) and `mod_en`=0, the pin equals `uart_tx` XOR `invert`.
- R3: The carrier is high while the phase is below a high length set by the duty code. That length is (4 − code) × `CARRIER_DIV`/8 clocks: code 0 gives 50 %, 1 gives 37.5 %, 2 gives 25 % and 3 gives 12.5 %.
- R4: With source select 0, `mod_en`=1 and `uart_tx`=1, the pin sits at its idle level, which is 0 XOR `invert`.
- R5: With source select 0, `mod_en`=1 and `uart_tx`=0, the pin equals the carrier XOR `invert`.
- R6: Source select 1 passes `gpo_bit`, 2 passes `real_pulse` and 3 passes `reactive_pulse`, each XOR `invert`. For these sources, `mod_en` and `duty_sel` have no effect on the pin.
- R7: Setting `invert` to 1 flips the pin relative to `invert`=0 for every source and mode.
- R8: While `rst_n` is low, the pin is 0, and the carrier phase is cleared.
- R9: The pin changes on the clock edge that follows the cycle in which its inputs were presented. The latency is exactly one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_tx | input | 1 | UART serial transmit bit |
| gpo_bit | input | 1 | General-purpose output bit |
| real_pulse | input | 1 | Real-energy pulse |
| reactive_pulse | input | 1 | Reactive-energy pulse |
| src_sel | input | 2 | Source select: 0 UART, 1 GPO, 2 real pulse, 3 reactive pulse |
| mod_en | input | 1 | 1 = modulate the UART source with the carrier |
| duty_sel | input | 2 | Carrier duty code (0..3 = 50/37.5/25/12.5 %) |
| invert | input | 1 | Flip the final pin polarity |
| opt_tx | output | 1 | Optical transmit pin |

## Verification
On every clock, the assertions check the divider wrap and the reset level. They also check the one-clock relation between the inputs and the pin for pass-through, for the marks of modulated mode, for the non-UART sources, and for the carrier-off part of a modulated space. Only the bench scenarios can show the whole carrier waveform. These are full periods under each duty code, where the bench counts high clocks against the expected eighths. They also include phase restart after a reset in mid-run and random mixes of source, mode and polarity changes checked against an independent model.

// File: rtl/optx_pkg.sv
package optx_pkg;

    typedef enum logic [1:0] {
        SRC_UART  = 2'd0,
        SRC_GPO   = 2'd1,
        SRC_REAL  = 2'd2,
        SRC_REACT = 2'd3
    } optx_src_e;

    typedef struct packed {
        logic pin;
    } optx_out_s;

endpackage

// File: rtl/optx_carrier_gen.sv
module optx_carrier_gen #(
    parameter int CARRIER_DIV = 5264,
    localparam int CW = $clog2(CARRIER_DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    duty_sel,
    output logic          carrier,
    output logic [CW-1:0] phase
);
    localparam int EIGHTH = CARRIER_DIV / 8;
    localparam logic [CW-1:0] LAST = CW'(CARRIER_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } car_state_s;

    car_state_s st_d, st_q;
    logic [CW:0] high_len;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // high length in eighths of the period, derived from the divider count
    always_comb begin
        unique case (duty_sel)
            2'd0:    high_len = (CW+1)'(4 * EIGHTH);
            2'd1:    high_len = (CW+1)'(3 * EIGHTH);
            2'd2:    high_len = (CW+1)'(2 * EIGHTH);
            default: high_len = (CW+1)'(EIGHTH);
        endcase
    end

    assign carrier = ({1'b0, st_q.cnt} < high_len);
    assign phase   = st_q.cnt;

endmodule

// File: rtl/optx_src_mux.sv
module optx_src_mux
    import optx_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       uart_tx,
    input  logic       gpo_bit,
    input  logic       real_pulse,
    input  logic       reactive_pulse,
    input  logic       mod_en,
    input  logic       carrier,
    output logic       raw
);
    logic uart_level;

    // modulated: space keys the carrier, mark stays low
    assign uart_level = mod_en ? (~uart_tx & carrier) : uart_tx;

    always_comb begin
        unique case (optx_src_e'(src_sel))
            SRC_UART:  raw = uart_level;
            SRC_GPO:   raw = gpo_bit;
            SRC_REAL:  raw = real_pulse;
            default:   raw = reactive_pulse;
        endcase
    end

endmodule

// File: rtl/optx_out_stage.sv
module optx_out_stage
    import optx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    output logic pin
);
    optx_out_s out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.pin = raw ^ invert;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pin = out_q.pin;

endmodule

// File: rtl/optx_modulator.sv
module optx_modulator #(
    parameter int CARRIER_DIV = 5264,
    localparam int CW = $clog2(CARRIER_DIV)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uart_tx,
    input  logic       gpo_bit,
    input  logic       real_pulse,
    input  logic       reactive_pulse,
    input  logic [1:0] src_sel,
    input  logic       mod_en,
    input  logic [1:0] duty_sel,
    input  logic       invert,
    output logic       opt_tx
);
    logic          carrier;
    logic [CW-1:0] car_phase;
    logic          raw;

    optx_carrier_gen #(.CARRIER_DIV(CARRIER_DIV)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_sel (duty_sel),
        .carrier  (carrier),
        .phase    (car_phase)
    );

    optx_src_mux u_mux (
        .src_sel        (src_sel),
        .uart_tx        (uart_tx),
        .gpo_bit        (gpo_bit),
        .real_pulse     (real_pulse),
        .reactive_pulse (reactive_pulse),
        .mod_en         (mod_en),
        .carrier        (carrier),
        .raw            (raw)
    );

    optx_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw),
        .invert (invert),
        .pin    (opt_tx)
    );

endmodule

// File: rtl/optx_modulator_chk.sv
module optx_modulator_chk #(
    parameter int CARRIER_DIV = 5264,
    localparam int CW = $clog2(CARRIER_DIV)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uart_tx,
    input logic          gpo_bit,
    input logic          real_pulse,
    input logic          reactive_pulse,
    input logic [1:0]    src_sel,
    input logic          mod_en,
    input logic [1:0]    duty_sel,
    input logic          invert,
    input logic          opt_tx,
    input logic [CW-1:0] phase
);
    localparam int EIGHTH = CARRIER_DIV / 8;

    logic [CW:0] off_from;
    assign off_from = (CW+1)'((4 - int'(duty_sel)) * EIGHTH);

    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CW'(CARRIER_DIV - 1)) |=> (phase == '0));

    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != CW'(CARRIER_DIV - 1)) |=> (phase == $past(phase) + CW'(1)));

    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd0 && !mod_en) |=> (opt_tx == $past(uart_tx ^ invert)));

    a_r4_mark_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd0 && mod_en && uart_tx) |=> (opt_tx == $past(invert)));

    a_r5_space_off: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd0 && mod_en && !uart_tx && {1'b0, phase} >= off_from)
        |=> (opt_tx == $past(invert)));

    a_r6_gpo: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd1) |=> (opt_tx == $past(gpo_bit ^ invert)));

    a_r6_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[1]) |=> (opt_tx == $past((src_sel[0] ? reactive_pulse : real_pulse) ^ invert)));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_low: assert (opt_tx == 1'b0 && phase == '0);
        end
    end

endmodule

bind optx_modulator optx_modulator_chk #(.CARRIER_DIV(CARRIER_DIV)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .uart_tx        (uart_tx),
    .gpo_bit        (gpo_bit),
    .real_pulse     (real_pulse),
    .reactive_pulse (reactive_pulse),
    .src_sel        (src_sel),
    .mod_en         (mod_en),
    .duty_sel       (duty_sel),
    .invert         (invert),
    .opt_tx         (opt_tx),
    .phase          (car_phase)
);

// File: tb/optx_modulator_tb.sv
`timescale 1ns/1ps
module optx_modulator_tb;
    localparam int DIV = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_tx = 1'b1, gpo_bit = 1'b0, real_pulse = 1'b0, reactive_pulse = 1'b0;
    logic [1:0] src_sel = 2'd0, duty_sel = 2'd0;
    logic mod_en = 1'b0, invert = 1'b0;
    logic opt_tx;

    int n_checks = 0;
    int n_fail = 0;
    int m_phase = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    optx_modulator #(.CARRIER_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .uart_tx(uart_tx), .gpo_bit(gpo_bit),
        .real_pulse(real_pulse), .reactive_pulse(reactive_pulse),
        .src_sel(src_sel), .mod_en(mod_en), .duty_sel(duty_sel),
        .invert(invert), .opt_tx(opt_tx)
    );

    function automatic logic model_pin(input logic [1:0] s, input logic tx, input logic g,
                                       input logic rp, input logic vp, input logic me,
                                       input logic [1:0] d, input logic inv, input int ph);
        logic car, r;
        car = (ph < (4 - int'(d)) * (DIV / 8));
        case (s)
            2'd0:    r = me ? (!tx && car) : tx;
            2'd1:    r = g;
            2'd2:    r = rp;
            default: r = vp;
        endcase
        return r ^ inv;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: opt_tx=%b expected %b (phase %0d)", req, act, exp, m_phase);
        end
    endtask

    // inputs already driven at a negedge; run one edge and check at the next negedge
    task automatic step(input string req);
        logic e;
        e = model_pin(src_sel, uart_tx, gpo_bit, real_pulse, reactive_pulse,
                      mod_en, duty_sel, invert, m_phase);
        @(posedge clk);
        m_phase = (m_phase + 1) % DIV;
        @(negedge clk);
        check(req, opt_tx, e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        check("R8", opt_tx, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R8", opt_tx, 1'b0);
        rst_n = 1'b1;
        m_phase = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1/R3/R5: full periods for each duty code, counting high clocks
        for (int d = 0; d < 4; d++) begin
            int highs;
            src_sel = 2'd0; mod_en = 1'b1; uart_tx = 1'b0; invert = 1'b0;
            duty_sel = 2'(d);
            while (m_phase != 0) step("R1");
            highs = 0;
            for (int k = 0; k < DIV; k++) begin
                step("R5");
                highs += int'(opt_tx);
            end
            n_checks++;
            if (highs != (4 - d) * DIV / 8) begin
                n_fail++;
                $display("FAIL R3: high clocks %0d expected %0d (duty %0d)", highs, (4 - d) * DIV / 8, d);
            end
        end

        // R4 + R7: mark stays idle, both polarities
        uart_tx = 1'b1;
        for (int k = 0; k < DIV; k++) begin invert = k[3]; step("R4"); end

        // R2 / R9: pass-through toggles one clock late
        mod_en = 1'b0;
        for (int k = 0; k < 20; k++) begin uart_tx = k[0]; invert = k[2]; step("R9"); end

        // R6: other sources ignore mod_en and duty
        for (int s = 1; s < 4; s++) begin
            src_sel = 2'(s);
            for (int k = 0; k < 16; k++) begin
                gpo_bit = k[0]; real_pulse = k[1]; reactive_pulse = k[2];
                mod_en = k[3]; duty_sel = 2'(k); uart_tx = 1'b0;
                step("R6");
            end
        end

        // R8 + R1: mid-run reset restarts the carrier phase
        src_sel = 2'd0; mod_en = 1'b1; uart_tx = 1'b0; duty_sel = 2'd3; invert = 1'b1;
        for (int k = 0; k < 21; k++) step("R5");
        do_reset();
        for (int k = 0; k < DIV + 4; k++) step("R1");

        // R7 and general: constrained random mix
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom);
            uart_tx = r[0]; gpo_bit = r[1]; real_pulse = r[2]; reactive_pulse = r[3];
            if (r[7:4] == 4'd0) src_sel = r[9:8];
            if (r[13:10] == 4'd0) mod_en = r[14];
            if (r[19:15] == 5'd0) duty_sel = r[21:20];
            if (r[26:22] == 5'd0) invert = r[27];
            step("R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule